// File: doc/BRIEF.md
# Buffered Serial Transmitter with Idle Lead-In

This block is the transmit half of an asynchronous serial port. Software writes one byte into a holding register. The transmitter moves that byte into a shift register at a frame boundary and sends it as a frame on a single line. A frame is one low start bit, eight data bits sent least significant bit first, and one high stop bit. The block runs one bit per pulse of an external bit-rate tick. It does not generate its own baud rate.

Raising the enable does three things. It claims the shared port pin as an output. It starts a lead-in of ten mark (high) bits, and only after that does the transmitter look at the holding register. The holding-register-empty flag is set when the byte is copied into the shift register, not when the frame ends. Software can therefore queue the next byte while the current one is still on the line, and frames can follow each other with no gap. An interrupt request is raised while the flag is set and interrupts are enabled.

The state machine has five named states:
- `S_OFF`: disabled.
- `S_LEAD`: sending the lead-in.
- `S_READY`: waiting at a frame boundary.
- `S_SHIFT`: sending data bits.
- `S_STOP`: sending the stop bit.

The transitions are:
- `S_OFF` goes to `S_LEAD` when enabled.
- `S_LEAD` goes to `S_READY` on the tenth tick.
- `S_READY` goes to `S_SHIFT` on a tick when a byte is waiting. This tick sends the start bit.
- `S_SHIFT` goes to `S_STOP` on the eighth data tick.
- `S_STOP` goes to `S_READY` on the stop tick.
- Any state goes to `S_OFF` when the enable is low.

Top module: `mark_lead_tx`

## Requirements
- R1: After reset, `txd` is 1, `buf_empty` is 1, and `irq` is 0 while `irq_en` is 0.
- R2: `pin_dir_out` is 1 exactly while `tx_en` is 1.
- R3: After `tx_en` rises, the first ten ticks each drive `txd` to 1, even if a byte is already waiting.
- R4: At a frame boundary with `buf_empty` set, a tick keeps `txd` at 1 and starts no frame.
- R5: At a frame-boundary tick with a byte waiting, the byte is copied into the shift register. On that same clock edge, `txd` becomes 0 (the start bit) and `buf_empty` becomes 1.
- R6: The next eight ticks drive `txd` with data bits 0 through 7 in that order, least significant bit first.
- R7: The tick after the last data bit drives `txd` to 1 (the stop bit). If a byte is waiting, the very next tick starts the next frame, so frames are 10 ticks apart.
- R8: A write pulse `wr_stb` stores `wr_data` and clears `buf_empty` on the following edge. If a write and a load happen on the same edge, the write wins.
- R9: `irq` equals `buf_empty AND irq_en`.
- R10: When `tx_en` is low at a clock edge, `txd` is 1 after that edge and the state returns to `S_OFF`. Enabling again repeats the ten-bit lead-in.
- R11: While enabled, `txd` changes only at an edge where `bit_tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmitter enable |
| bit_tick | input | 1 | One-clock pulse per bit time |
| wr_stb | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to transmit |
| irq_en | input | 1 | Transmit interrupt enable |
| txd | output | 1 | Serial line, idle high |
| pin_dir_out | output | 1 | Forces the shared port pin to output |
| buf_empty | output | 1 | Holding register is free |
| irq | output | 1 | Transmit interrupt request |

## Verification
The bench queues a byte before enabling the transmitter. A design that skipped or shortened the lead-in would put a start bit inside the first ten ticks. The next byte is written right after each start bit, which checks the no-gap case. A design that set the flag at the end of the frame would show `buf_empty` low after the start tick, and its frames would drift apart. Disabling the transmitter in the middle of a frame must return the line to mark on the next clock and must restart the lead-in. A design that resumed the old frame would send a start bit too early. Holding the tick low during a frame checks that the line does not move between ticks.

// File: rtl/mlt_pkg.sv
package mlt_pkg;
    typedef enum logic [2:0] {
        S_OFF   = 3'd0,
        S_LEAD  = 3'd1,
        S_READY = 3'd2,
        S_SHIFT = 3'd3,
        S_STOP  = 3'd4
    } mlt_state_e;
endpackage

// File: rtl/mlt_hold_reg.sv
// Holding register and its empty flag; a CPU write beats a same-cycle load.
module mlt_hold_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              load,
    output logic [DATA_W-1:0] hold_q,
    output logic              empty_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q  <= '0;
            empty_q <= 1'b1;
        end else if (wr_stb) begin
            hold_q  <= wr_data;
            empty_q <= 1'b0;
        end else if (load) begin
            empty_q <= 1'b1;
        end
    end
endmodule

// File: rtl/mlt_shifter.sv
// Right-shifting register; bit 0 is the next data bit to go out.
module mlt_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [DATA_W-1:0] par_in,
    output logic              lsb
);
    logic [DATA_W-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (load) begin
            sr_q <= par_in;
        end else if (shift) begin
            sr_q <= {1'b0, sr_q[DATA_W-1:1]};
        end
    end

    assign lsb = sr_q[0];
endmodule

// File: rtl/mlt_seq.sv
// Frame sequencer: lead-in, ready, data shifting, stop.
module mlt_seq
    import mlt_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int LEAD_BITS = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_en,
    input  logic       bit_tick,
    input  logic       empty,
    input  logic       sr_lsb,
    output logic       load,
    output logic       shift,
    output logic       txd,
    output mlt_state_e state
);
    localparam int MAX_CNT = (LEAD_BITS > DATA_W) ? LEAD_BITS : DATA_W;
    localparam int CNT_W   = $clog2(MAX_CNT + 1);
    localparam logic [CNT_W-1:0] LEAD_LAST = CNT_W'(LEAD_BITS - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

    mlt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             txd_q;

    // Strobes to the datapath
    assign load  = tx_en && bit_tick && (state_q == S_READY) && !empty;
    assign shift = tx_en && bit_tick && (state_q == S_SHIFT);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (!tx_en) begin
            state_d = S_OFF;
        end else begin
            unique case (state_q)
                S_OFF:   state_d = S_LEAD;
                S_LEAD:  if (bit_tick && cnt_q == LEAD_LAST) state_d = S_READY;
                S_READY: if (bit_tick && !empty) state_d = S_SHIFT;
                S_SHIFT: if (bit_tick && cnt_q == DATA_LAST) state_d = S_STOP;
                S_STOP:  if (bit_tick) state_d = S_READY;
                default: state_d = S_OFF;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_OFF;
        else        state_q <= state_d;
    end

    // Outputs: line level and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txd_q <= 1'b1;
            cnt_q <= '0;
        end else if (!tx_en) begin
            txd_q <= 1'b1;
            cnt_q <= '0;
        end else if (bit_tick) begin
            unique case (state_q)
                S_OFF: begin
                    txd_q <= 1'b1;
                    cnt_q <= '0;
                end
                S_LEAD: begin
                    txd_q <= 1'b1;
                    cnt_q <= (cnt_q == LEAD_LAST) ? '0 : cnt_q + 1'b1;
                end
                S_READY: begin
                    txd_q <= empty;
                    cnt_q <= '0;
                end
                S_SHIFT: begin
                    txd_q <= sr_lsb;
                    cnt_q <= (cnt_q == DATA_LAST) ? '0 : cnt_q + 1'b1;
                end
                S_STOP: begin
                    txd_q <= 1'b1;
                    cnt_q <= '0;
                end
                default: begin
                    txd_q <= 1'b1;
                    cnt_q <= '0;
                end
            endcase
        end else if (state_q == S_OFF) begin
            cnt_q <= '0;
        end
    end

    assign txd   = txd_q;
    assign state = state_q;
endmodule

// File: rtl/mark_lead_tx.sv
module mark_lead_tx
    import mlt_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int LEAD_BITS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              bit_tick,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              irq_en,
    output logic              txd,
    output logic              pin_dir_out,
    output logic              buf_empty,
    output logic              irq
);
    logic              load, shift, sr_lsb;
    logic [DATA_W-1:0] hold_q;
    mlt_state_e        state;

    mlt_hold_reg #(.DATA_W(DATA_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
        .load(load), .hold_q(hold_q), .empty_q(buf_empty)
    );

    mlt_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(load), .shift(shift),
        .par_in(hold_q), .lsb(sr_lsb)
    );

    mlt_seq #(.DATA_W(DATA_W), .LEAD_BITS(LEAD_BITS)) u_seq (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .bit_tick(bit_tick),
        .empty(buf_empty), .sr_lsb(sr_lsb), .load(load), .shift(shift),
        .txd(txd), .state(state)
    );

    assign pin_dir_out = tx_en;
    assign irq         = buf_empty & irq_en;
endmodule

// File: rtl/mlt_checker.sv
module mlt_checker (
    input logic clk,
    input logic rst_n,
    input logic tx_en,
    input logic bit_tick,
    input logic wr_stb,
    input logic txd,
    input logic buf_empty
);
    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> txd); // R10
    AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !buf_empty); // R8
    AST_LOAD_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_empty) |-> !txd); // R5
    AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && !bit_tick) |=> $stable(txd)); // R11
endmodule

bind mark_lead_tx mlt_checker u_chk (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .bit_tick(bit_tick),
    .wr_stb(wr_stb), .txd(txd), .buf_empty(buf_empty)
);

// File: tb/sim_mark_lead_tx.sv
module sim_mark_lead_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0;
    logic       bit_tick = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = '0;
    logic       irq_en = 1'b0;
    logic       txd, pin_dir_out, buf_empty, irq;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    // Frame vectors: byte written and expected line levels, tick 0 in bit 0
    localparam int NV = 4;
    localparam logic [7:0] V_D [NV] = '{8'hA5, 8'h00, 8'hFF, 8'h3C};
    localparam logic [9:0] V_F [NV] = '{10'b1101001010, 10'b1000000000,
                                        10'b1111111110, 10'b1001111000};

    always #10 clk = ~clk;

    mark_lead_tx u0 (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .bit_tick(bit_tick),
        .wr_stb(wr_stb), .wr_data(wr_data), .irq_en(irq_en),
        .txd(txd), .pin_dir_out(pin_dir_out), .buf_empty(buf_empty), .irq(irq)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            total = total + 1;
            bad   = bad + 1;
            $display("FAIL watchdog act=%0d exp=0", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic tick(output logic b);
        @(negedge clk) bit_tick = 1'b1;
        @(negedge clk) bit_tick = 1'b0;
        b = txd;
    endtask

    task automatic write(input logic [7:0] d);
        @(negedge clk) begin wr_stb = 1'b1; wr_data = d; end
        @(negedge clk) wr_stb = 1'b0;
    endtask

    initial begin
        logic       b;
        logic [9:0] fr;

        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 txd", 32'(txd), 32'd1);
        chk("R1 empty", 32'(buf_empty), 32'd1);
        chk("R1 irq", 32'(irq), 32'd0);
        chk("R2 dir off", 32'(pin_dir_out), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8 write while disabled
        write(V_D[0]);
        chk("R8 write clears", 32'(buf_empty), 32'd0);

        @(negedge clk) tx_en = 1'b1;
        @(negedge clk);
        chk("R2 dir on", 32'(pin_dir_out), 32'd1);

        // R3 lead-in despite pending byte
        for (int k = 0; k < 10; k++) begin
            tick(b);
            chk("R3 lead mark", 32'(b), 32'd1);
        end

        // Table walk: back-to-back frames (R5 R6 R7 R8)
        for (int i = 0; i < NV; i++) begin
            fr = '0;
            tick(b);
            fr[0] = b;
            chk("R5 empty at load", 32'(buf_empty), 32'd1);
            if (i + 1 < NV) begin
                write(V_D[i+1]);
                chk("R8 queued", 32'(buf_empty), 32'd0);
            end
            for (int k = 1; k < 10; k++) begin
                tick(b);
                fr[k] = b;
            end
            chk("R6 R7 frame", 32'(fr), 32'(V_F[i]));
        end

        // R4 idle with nothing queued
        for (int k = 0; k < 3; k++) begin
            tick(b);
            chk("R4 idle mark", 32'(b), 32'd1);
        end
        chk("R4 still empty", 32'(buf_empty), 32'd1);

        // R9 interrupt level
        chk("R9 irq off", 32'(irq), 32'd0);
        @(negedge clk) irq_en = 1'b1;
        #1 chk("R9 irq on", 32'(irq), 32'd1);
        write(8'hC3);
        chk("R9 irq after write", 32'(irq), 32'd0);

        // R10 disable mid-frame
        tick(b);
        chk("R5 start", 32'(b), 32'd0);
        chk("R9 irq after load", 32'(irq), 32'd1);
        tick(b);
        tick(b);
        @(negedge clk) tx_en = 1'b0;
        @(negedge clk);
        chk("R10 mark on disable", 32'(txd), 32'd1);
        chk("R2 dir released", 32'(pin_dir_out), 32'd0);

        @(negedge clk) tx_en = 1'b1;
        write(8'h81);
        for (int k = 0; k < 10; k++) begin
            tick(b);
            chk("R10 lead again", 32'(b), 32'd1);
        end
        fr = '0;
        tick(b);
        fr[0] = b;
        // R11 no movement between ticks
        repeat (5) @(negedge clk);
        chk("R11 stable", 32'(txd), 32'd0);
        for (int k = 1; k < 10; k++) begin
            tick(b);
            fr[k] = b;
        end
        chk("R6 frame 81", 32'(fr), 32'(10'b1100000010));

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule